// File: doc/BRIEF.md
# Instruction Fetch, Decode and Skip Sequencer

This block is the front end of a small 16-bit processor. It reads instruction words through a word-wide memory read port and keeps the program counter. It gathers every word of an instruction and presents the decoded first word to the operand and execute stages: opcode, operand field codes, the word count and the extra words. In the first word, the 4-bit opcode sits in bits [3:0]. For a basic instruction, operand a is in bits [9:4] and operand b is in bits [15:10]. A zero opcode marks a non-basic instruction, which carries an extended opcode in bits [9:4] and its single operand in bits [15:10].

The execute stage accepts a decoded instruction with `ex_ready`. On that same cycle it can load a new program counter value, or it can report that a conditional test failed. A failed test makes the block skip the whole next instruction in one extra cycle. The length of the skipped instruction comes from its first word, and the skip triggers no operand side effects. A non-basic word whose extended opcode is anything other than 1, the subroutine call, is dropped as a one-word no-op and flagged as illegal.

Top module: `insn_seq`

## Requirements
- R1: After reset, `mem_addr` is 0, `mem_rd` is 1, and `dec_valid` and `illegal` are 0.
- R2: For a first word with a nonzero opcode, `dec_basic`=1, `dec_opcode`=word[3:0], `dec_opnd_a`=word[9:4], `dec_opnd_b`=word[15:10] and `dec_ext_op`=0.
- R3: For a first word with opcode 0 and extended opcode 1, `dec_basic`=0, `dec_opcode`=0, `dec_ext_op`=word[9:4], `dec_opnd_a`=word[15:10] and `dec_opnd_b`=0.
- R4: `dec_len` is 1 plus one for each operand code that needs a word: codes 0x10 to 0x17, 0x1e and 0x1f. `dec_word1` and `dec_word2` hold the extra words in address order.
- R5: Each word read uses the word at `mem_addr`, and `mem_addr` then rises by one, wrapping from 0xffff to 0. An N-word instruction takes N cycles of fetch before `dec_valid` rises.
- R6: `dec_valid` and all decoded outputs hold steady until `ex_ready`. After an accept with no load, fetching resumes at the word that follows the instruction.
- R7: `pc_load` with `ex_ready` while `dec_valid` makes the next fetch start at `pc_load_val`.
- R8: `test_fail` with `ex_ready` while `dec_valid` causes exactly one skip cycle (`skip_busy`=1). That cycle reads the next first word and advances `mem_addr` by its length. The skipped instruction is never presented.
- R9: A non-basic word whose extended opcode is not 1 is never presented. It pulses `illegal` for one cycle and occupies one word, whatever its operand field holds.
- R10: A skipped reserved non-basic word advances the address by one and raises no `illegal` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | ADDR_W | Read address; equals the return address while an instruction is presented |
| mem_rd | output | 1 | Read strobe for the current cycle |
| mem_rdata | input | 16 | Word at `mem_addr`, same cycle |
| ex_ready | input | 1 | Execute stage accepts the presented instruction |
| test_fail | input | 1 | With `ex_ready`: conditional test failed, skip next instruction |
| pc_load | input | 1 | With `ex_ready`: redirect fetch |
| pc_load_val | input | ADDR_W | Redirect target |
| dec_valid | output | 1 | Decoded instruction presented |
| dec_basic | output | 1 | Instruction is basic |
| dec_opcode | output | 4 | Basic opcode |
| dec_ext_op | output | 6 | Extended opcode (non-basic) |
| dec_opnd_a | output | 6 | Operand a code |
| dec_opnd_b | output | 6 | Operand b code (basic only) |
| dec_len | output | 2 | Instruction length in words |
| dec_word1 | output | 16 | First extra word |
| dec_word2 | output | 16 | Second extra word |
| skip_busy | output | 1 | Skip cycle in progress |
| illegal | output | 1 | Reserved non-basic word dropped |

## Verification
The assertions take for granted that the execute stage reports a failed test only for the four conditional opcodes (0xc to 0xf) and never asks for a load and a skip in the same accept. The stimulus keeps to these rules by choosing the skip only after it has seen a conditional opcode, and by choosing a load only when it is not skipping. The program memory is filled from a fixed-seed random source, so reserved words, chains of them and every operand-length mix occur. Directed words at the start cover a three-word skip, the skip of a reserved word, and a three-word fetch that wraps past 0xffff.

// File: rtl/insn_pkg.sv
package insn_pkg;
    localparam int WORD_W   = 16;
    localparam int OPC_W    = 4;
    localparam int FLD_W    = 6;
    localparam int LEN_W    = 2;
    localparam logic [FLD_W-1:0] EXT_CALL = 6'h01;

    typedef enum logic [2:0] {
        ST_FETCH0,
        ST_FETCH1,
        ST_FETCH2,
        ST_ISSUE,
        ST_SKIP
    } seq_state_e;

    // Operand codes that pull one extra word from the instruction stream
    function automatic logic fld_needs_word(input logic [FLD_W-1:0] code);
        return (code[5:3] == 3'b010) || (code == 6'h1e) || (code == 6'h1f);
    endfunction
endpackage

// File: rtl/insn_len_calc.sv
module insn_len_calc
    import insn_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic [LEN_W-1:0]  len,
    output logic              reserved
);
    logic [OPC_W-1:0] opc;
    logic [FLD_W-1:0] fld_lo;
    logic [FLD_W-1:0] fld_hi;

    assign opc    = word[3:0];
    assign fld_lo = word[9:4];
    assign fld_hi = word[15:10];

    always_comb begin
        reserved = (opc == '0) && (fld_lo != EXT_CALL);
        if (reserved) begin
            len = LEN_W'(1);
        end else if (opc == '0) begin
            len = LEN_W'(1) + LEN_W'(fld_needs_word(fld_hi));
        end else begin
            len = LEN_W'(1) + LEN_W'(fld_needs_word(fld_lo))
                            + LEN_W'(fld_needs_word(fld_hi));
        end
    end
endmodule

// File: rtl/insn_field_split.sv
module insn_field_split
    import insn_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic              basic,
    output logic [OPC_W-1:0]  opcode,
    output logic [FLD_W-1:0]  ext_op,
    output logic [FLD_W-1:0]  opnd_a,
    output logic [FLD_W-1:0]  opnd_b,
    output logic              reserved
);
    always_comb begin
        opcode   = word[3:0];
        basic    = (opcode != '0);
        reserved = !basic && (word[9:4] != EXT_CALL);
        if (basic) begin
            ext_op = '0;
            opnd_a = word[9:4];
            opnd_b = word[15:10];
        end else begin
            ext_op = word[9:4];
            opnd_a = word[15:10];
            opnd_b = '0;
        end
    end
endmodule

// File: rtl/insn_seq.sv
module insn_seq
    import insn_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              ex_ready,
    input  logic              test_fail,
    input  logic              pc_load,
    input  logic [ADDR_W-1:0] pc_load_val,
    output logic              dec_valid,
    output logic              dec_basic,
    output logic [OPC_W-1:0]  dec_opcode,
    output logic [FLD_W-1:0]  dec_ext_op,
    output logic [FLD_W-1:0]  dec_opnd_a,
    output logic [FLD_W-1:0]  dec_opnd_b,
    output logic [LEN_W-1:0]  dec_len,
    output logic [WORD_W-1:0] dec_word1,
    output logic [WORD_W-1:0] dec_word2,
    output logic              skip_busy,
    output logic              illegal
);
    localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(1);

    typedef struct packed {
        seq_state_e        state;
        logic [ADDR_W-1:0] pc;
        logic [WORD_W-1:0] ir;
        logic [WORD_W-1:0] w1;
        logic [WORD_W-1:0] w2;
        logic [LEN_W-1:0]  len;
        logic              illegal;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;

    logic [LEN_W-1:0]  rd_len;
    logic              rd_reserved;
    logic [ADDR_W-1:0] skip_step;
    logic              ir_reserved;

    // Length of whatever first word the port returns this cycle
    insn_len_calc u_len (
        .word     (mem_rdata),
        .len      (rd_len),
        .reserved (rd_reserved)
    );

    // Fields of the held instruction
    insn_field_split u_split (
        .word     (seq_q.ir),
        .basic    (dec_basic),
        .opcode   (dec_opcode),
        .ext_op   (dec_ext_op),
        .opnd_a   (dec_opnd_a),
        .opnd_b   (dec_opnd_b),
        .reserved (ir_reserved)
    );

    assign skip_step = {{(ADDR_W-LEN_W){1'b0}}, rd_len};

    always_comb begin
        seq_d         = seq_q;
        seq_d.illegal = 1'b0;
        mem_rd        = 1'b0;
        unique case (seq_q.state)
            ST_FETCH0: begin
                mem_rd   = 1'b1;
                seq_d.ir = mem_rdata;
                seq_d.pc = seq_q.pc + PC_STEP;
                if (rd_reserved) begin
                    seq_d.illegal = 1'b1;
                end else begin
                    seq_d.len   = rd_len;
                    seq_d.state = (rd_len == LEN_W'(1)) ? ST_ISSUE : ST_FETCH1;
                end
            end
            ST_FETCH1: begin
                mem_rd      = 1'b1;
                seq_d.w1    = mem_rdata;
                seq_d.pc    = seq_q.pc + PC_STEP;
                seq_d.state = (seq_q.len == LEN_W'(3)) ? ST_FETCH2 : ST_ISSUE;
            end
            ST_FETCH2: begin
                mem_rd      = 1'b1;
                seq_d.w2    = mem_rdata;
                seq_d.pc    = seq_q.pc + PC_STEP;
                seq_d.state = ST_ISSUE;
            end
            ST_ISSUE: begin
                if (ex_ready) begin
                    if (pc_load) seq_d.pc = pc_load_val;
                    seq_d.state = test_fail ? ST_SKIP : ST_FETCH0;
                end
            end
            ST_SKIP: begin
                mem_rd      = 1'b1;
                seq_d.pc    = seq_q.pc + skip_step;
                seq_d.state = ST_FETCH0;
            end
            default: seq_d.state = ST_FETCH0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.state   <= ST_FETCH0;
            seq_q.pc      <= '0;
            seq_q.ir      <= '0;
            seq_q.w1      <= '0;
            seq_q.w2      <= '0;
            seq_q.len     <= '0;
            seq_q.illegal <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign mem_addr  = seq_q.pc;
    assign dec_valid = (seq_q.state == ST_ISSUE);
    assign skip_busy = (seq_q.state == ST_SKIP);
    assign dec_len   = seq_q.len;
    assign dec_word1 = seq_q.w1;
    assign dec_word2 = seq_q.w2;
    assign illegal   = seq_q.illegal;

    // Input rule: only conditional opcodes fail, never together with a load (R8)
    p_fail_cond_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && ex_ready && test_fail)
            |-> (dec_basic && dec_opcode[3:2] == 2'b11 && !pc_load));

    p_fetch_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !skip_busy) |=> (mem_addr == $past(mem_addr) + PC_STEP));

    p_skip_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        skip_busy |=> (!skip_busy && !dec_valid
                       && mem_addr == $past(mem_addr) + $past(skip_step)));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !ex_ready) |=> (dec_valid && $stable(dec_opcode)
            && $stable(dec_opnd_a) && $stable(dec_opnd_b)
            && $stable(dec_word1) && $stable(dec_word2) && $stable(mem_addr)));

    p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && ex_ready && pc_load) |=> (mem_addr == $past(pc_load_val)));

    p_len_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> (dec_len != '0));

    p_no_reserved_issue_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> (!ir_reserved && !illegal));

    p_skip_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        skip_busy |=> !illegal);
endmodule

// File: tb/insn_seq_tb.sv
module insn_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N_INSN     = 400;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic [15:0] mem_rdata;
    logic        ex_ready, test_fail, pc_load;
    logic [15:0] pc_load_val;
    logic        dec_valid, dec_basic;
    logic [3:0]  dec_opcode;
    logic [5:0]  dec_ext_op, dec_opnd_a, dec_opnd_b;
    logic [1:0]  dec_len;
    logic [15:0] dec_word1, dec_word2;
    logic        skip_busy, illegal;

    logic [15:0] mem [0:255];
    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign mem_rdata = mem[mem_addr[7:0]];

    insn_seq u_dut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_rdata(mem_rdata), .ex_ready(ex_ready), .test_fail(test_fail),
        .pc_load(pc_load), .pc_load_val(pc_load_val), .dec_valid(dec_valid),
        .dec_basic(dec_basic), .dec_opcode(dec_opcode), .dec_ext_op(dec_ext_op),
        .dec_opnd_a(dec_opnd_a), .dec_opnd_b(dec_opnd_b), .dec_len(dec_len),
        .dec_word1(dec_word1), .dec_word2(dec_word2), .skip_busy(skip_busy),
        .illegal(illegal)
    );

    function automatic logic needs_word(input logic [5:0] c);
        return (c >= 6'h10 && c <= 6'h17) || c == 6'h1e || c == 6'h1f;
    endfunction
    function automatic logic is_reserved(input logic [15:0] w);
        return w[3:0] == 4'h0 && w[9:4] != 6'h01;
    endfunction
    function automatic int word_len(input logic [15:0] w);
        if (is_reserved(w)) return 1;
        if (w[3:0] == 4'h0) return 1 + int'(needs_word(w[15:10]));
        return 1 + int'(needs_word(w[9:4])) + int'(needs_word(w[15:10]));
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            finish_run();
        end
    end

    logic [15:0] mpc;
    logic        exp_skip;
    logic        after_load;
    logic [15:0] load_tgt;
    logic [15:0] cur_w;

    // Waits for the next presented instruction and checks it against the model
    task automatic wait_decode();
        int exp_cyc = exp_skip ? 1 : 0;
        int exp_ill = 0;
        int cnt = 0;
        int ill = 0;
        int len;
        logic [15:0] w;
        if (after_load) check("R7 redirect address", 64'(mem_addr), 64'(load_tgt));
        if (exp_skip) check("R8 skip cycle flagged", 64'({skip_busy, mem_rd}), 64'(2'b11));
        if (exp_skip) mpc = mpc + 16'(word_len(mem[mpc[7:0]]));
        while (is_reserved(mem[mpc[7:0]])) begin
            exp_ill++;
            exp_cyc++;
            mpc = mpc + 16'd1;
        end
        w = mem[mpc[7:0]];
        len = word_len(w);
        exp_cyc += len;
        forever begin
            if (illegal) ill++;
            if (dec_valid) break;
            cnt++;
            if (cnt > 64) break;
            @(negedge clk);
        end
        check("R5 fetch cycles", 64'(cnt), 64'(exp_cyc));
        check("R9 illegal pulses", 64'(ill), 64'(exp_ill));
        if (w[3:0] != 4'h0)
            check("R2 basic fields",
                  64'({dec_basic, dec_opcode, dec_ext_op, dec_opnd_a, dec_opnd_b}),
                  64'({1'b1, w[3:0], 6'h00, w[9:4], w[15:10]}));
        else
            check("R3 non-basic fields",
                  64'({dec_basic, dec_opcode, dec_ext_op, dec_opnd_a, dec_opnd_b}),
                  64'({1'b0, 4'h0, w[9:4], w[15:10], 6'h00}));
        check("R4 length", 64'(dec_len), 64'(len));
        if (len >= 2) check("R4 first extra word", 64'(dec_word1), 64'(mem[8'(mpc + 16'd1)]));
        if (len == 3) check("R4 second extra word", 64'(dec_word2), 64'(mem[8'(mpc + 16'd2)]));
        mpc = mpc + 16'(len);
        check("R5 address after instruction", 64'(mem_addr), 64'(mpc));
        cur_w = w;
    endtask

    initial begin
        int seed_dummy;
        logic [63:0] snap;
        seed_dummy = $urandom(32'd7031);
        for (int i = 0; i < 256; i++) mem[i] = 16'($urandom);
        mem[0]    = 16'h0000;  // reserved, ext 0
        mem[1]    = 16'h7FE0;  // reserved, ext 0x3e, operand needs a word yet stays 1 word
        mem[2]    = 16'h7DEC;  // IFE [nw], nw  (3 words)
        mem[5]    = 16'h7DE1;  // SET [nw], nw  (3 words)
        mem[8]    = 16'h4010;  // call, operand 0x10 (2 words)
        mem[10]   = 16'h880D;  // IFN reg, short literal (1 word)
        mem[11]   = 16'h0000;  // reserved, to be skipped
        mem[8'hFE] = 16'h7DE2; // ADD [nw], nw (wraps to 0)

        rst_n = 1'b0; ex_ready = 1'b0; test_fail = 1'b0; pc_load = 1'b0; pc_load_val = '0;
        mpc = '0; exp_skip = 1'b0; after_load = 1'b0; load_tgt = '0; cur_w = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset outputs", 64'({mem_addr, mem_rd, dec_valid, illegal}),
              64'({16'h0000, 1'b1, 1'b0, 1'b0}));

        for (int n = 0; n < N_INSN; n++) begin
            int act;
            int hold;
            logic [15:0] tgt;
            wait_decode();
            tgt = 16'($urandom);
            case (n)
                0, 6:    act = 1;
                1:       begin act = 2; tgt = 16'hFFFE; end
                5:       begin act = 2; tgt = 16'h000A; end
                2, 3, 4: act = 0;
                default: begin
                    if (cur_w[3:2] == 2'b11 && ($urandom % 2) == 0) act = 1;
                    else if (($urandom % 4) == 0) act = 2;
                    else act = 0;
                end
            endcase
            hold = int'($urandom % 3);
            snap = {dec_valid, dec_opcode, dec_opnd_a, dec_opnd_b, dec_word1[13:0], dec_word2[13:0]};
            for (int h = 0; h < hold; h++) begin
                @(negedge clk);
                check("R6 held while not accepted",
                      {dec_valid, dec_opcode, dec_opnd_a, dec_opnd_b, dec_word1[13:0], dec_word2[13:0]},
                      snap);
            end
            ex_ready = 1'b1;
            test_fail = (act == 1);
            pc_load = (act == 2);
            pc_load_val = tgt;
            @(negedge clk);
            ex_ready = 1'b0; test_fail = 1'b0; pc_load = 1'b0;
            exp_skip = (act == 1);
            after_load = (act == 2);
            load_tgt = tgt;
            if (act == 2) mpc = tgt;
            if (n == 6) check("R10 skip of reserved word quiet", 64'(illegal), 64'(0));
        end
        finish_run();
    end
endmodule